// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block produces the timing of the external program and data memory bus for an 8-bit microcontroller core. It runs on the oscillator clock. It splits every machine cycle into twelve oscillator periods, and each cycle holds two six-period slots. In a plain cycle each slot fetches one instruction byte. The block pulses the address latch strobe at the start of the slot, puts the address on the shared low port and the high port, then releases the low port and pulls the program strobe low to read the byte. It keeps its own fetch pointer, which starts at 0000h and steps by one for each fetch. The core can redirect the pointer with a one-cycle jump request.

The core asks for a data transfer by holding a request with a direction, a pointer-width select, an address and write data. The request is sampled in the last period of a machine cycle. The next cycle then carries the transfer instead of two fetches. That cycle has only one latch pulse and no program strobe. The read or write strobe is active in the middle of the cycle. A narrow pointer puts the core's port register value on the high port instead of an address byte. A one-period done pulse ends the transfer, and for a read it carries the captured byte.

Top module: `xbus_sequencer`

## Requirements
- R1: While reset is active, the latch strobe is low, the program, read and write strobes are high, the low port is released and no valid or done pulse is raised. The first fetch after reset uses address 0000h, and the first period after release is phase 0 of a fetch cycle.
- R2: In a fetch cycle the latch strobe is high in periods 0 and 1 of each six-period slot (phases 0, 1, 6 and 7 of the machine cycle) and low in the other periods.
- R3: In a fetch cycle the program strobe is low in slot periods 3 to 5 and high otherwise. The low port is released whenever the program strobe is low.
- R4: In a fetch slot the low port drives address bits 7:0 in slot periods 0 to 2. The byte on the data input in slot period 5 is returned with a one-period valid pulse in the following period, and the fetch pointer then steps by one.
- R5: In a fetch slot the high port shows address bits 15:8 for all six periods, including when the pointer carries across a byte boundary.
- R6: A transfer request seen in phase 11 turns the next machine cycle into a transfer cycle. In that cycle the latch strobe is high only in phases 0 and 1 (the phase 6 pulse is skipped), the program strobe stays high for all twelve periods, and no instruction byte is returned. Fetching then resumes at the address that was due next.
- R7: In a read transfer the read strobe is low in phases 4 to 10 and the low port is released from phase 3 to phase 11. The data input is sampled in phase 10 and returned with a done pulse in phase 11.
- R8: In a write transfer the write strobe is low in phases 4 to 10. The low port is driven in all twelve phases, with write data from phase 3 to phase 11, so the data is stable when the strobe rises. The done pulse appears in phase 11.
- R9: The low port carries pointer bits 7:0 in phases 0 to 2 of a transfer. The high port shows pointer bits 15:8 when the wide select is 1 and the port register input when it is 0. All of these values are taken in phase 11, so later changes to the inputs have no effect.
- R10: The read and write strobes are never low together, and neither is low while the program strobe is low.
- R11: A jump request loads the fetch pointer, and the next fetch slot uses the jump address. A jump seen in the same period as a fetch capture takes priority over the step by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_req | input | 1 | Data transfer request, held until done |
| xfer_we | input | 1 | 1 = write transfer, 0 = read transfer |
| xfer_wide | input | 1 | 1 = 16-bit pointer, 0 = 8-bit pointer |
| xfer_addr | input | 16 | Transfer pointer |
| xfer_wdata | input | 8 | Write data |
| hi_port_val | input | 8 | High port register value, shown for 8-bit pointers |
| jump_valid | input | 1 | Load the fetch pointer |
| jump_addr | input | 16 | New fetch address |
| xfer_done | output | 1 | One-period transfer completion pulse |
| xfer_rdata | output | 8 | Read transfer data |
| instr_valid | output | 1 | One-period instruction byte pulse |
| instr_byte | output | 8 | Fetched instruction byte |
| bus_ale | output | 1 | Address latch strobe, active high |
| bus_psen_n | output | 1 | Program read strobe, active low |
| bus_rd_n | output | 1 | Data read strobe, active low |
| bus_wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Low port output value |
| ad_oe | output | 1 | Low port drive enable |
| ad_in | input | 8 | Low port input value |
| hi_addr | output | 8 | High port output value |

## Verification
Every bus output is a flop loaded from the next phase, so each pin reflects the phase that its edge has just entered. The bench keeps its own phase count from the reset release and samples on the falling edge. An instruction byte is due one period after slot period 5, in the next slot's period 0. Read data and the done pulse are due in phase 11, one period after the phase 10 sample. A transfer requested during phase 6 starts at the phase 0 that follows the next boundary. The bench changes the pointer, the direction and the port register input after phase 0 to show that only the phase 11 sample counts.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int HI_W   = ADDR_W - DATA_W;

    typedef enum logic [1:0] {
        K_IDLE  = 2'd0,
        K_FETCH = 2'd1,
        K_READ  = 2'd2,
        K_WRITE = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        logic              ale;
        logic              psen_n;
        logic              rd_n;
        logic              wr_n;
        logic              ad_oe;
        logic [DATA_W-1:0] ad;
        logic [HI_W-1:0]   hi;
    } pins_t;

    localparam pins_t PINS_IDLE = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                    ad_oe: 1'b0, ad: '0, hi: '1};
endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr #(
    parameter int CYC_LEN = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic [$clog2(CYC_LEN)-1:0] phase_q,
    output logic [$clog2(CYC_LEN)-1:0] phase_d,
    output logic                       at_last
);
    localparam int PH_W = $clog2(CYC_LEN);
    localparam logic [PH_W-1:0] P_LAST = PH_W'(CYC_LEN - 1);

    always_comb begin
        at_last = (phase_q == P_LAST);
        phase_d = at_last ? '0 : phase_q + 1'b1;
    end

    // Reset parks on the last phase so that the first edge after release enters phase 0.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= P_LAST;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/xbus_fetch_ptr.sv
module xbus_fetch_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          slot_start,
    input  logic          jump_valid,
    input  logic [AW-1:0] jump_addr,
    output logic [AW-1:0] cur_d,
    output logic [AW-1:0] cur_q
);
    typedef struct packed {
        logic [AW-1:0] next_pc;
        logic [AW-1:0] cur;
        logic          redirect;
    } ptr_t;

    ptr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // A jump wins over the step by one taken at a capture.
        if (jump_valid)
            st_d.next_pc = jump_addr;
        else if (capture && !st_q.redirect)
            st_d.next_pc = st_q.cur + AW'(1);

        if (slot_start)      st_d.redirect = 1'b0;
        else if (jump_valid) st_d.redirect = 1'b1;
        else if (capture)    st_d.redirect = 1'b0;

        if (slot_start) st_d.cur = st_d.next_pc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_d = st_d.cur;
    assign cur_q = st_q.cur;
endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec
    import xbus_pkg::*;
#(
    parameter int CYC_LEN = 12
) (
    input  logic [$clog2(CYC_LEN)-1:0] phase,
    input  cyc_kind_e                  kind,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output pins_t                      pins
);
    localparam int PH_W = $clog2(CYC_LEN);
    localparam int HALF = CYC_LEN / 2;
    localparam logic [PH_W-1:0] L_HALF = PH_W'(HALF);
    localparam logic [PH_W-1:0] L_ALE  = PH_W'(HALF / 3);      // latch strobe width
    localparam logic [PH_W-1:0] L_ADR  = PH_W'(HALF / 2);      // address drive width
    localparam logic [PH_W-1:0] L_STB0 = PH_W'(HALF / 2 + 1);  // first data strobe phase
    localparam logic [PH_W-1:0] L_STB1 = PH_W'(CYC_LEN - 2);   // last data strobe phase

    logic [PH_W-1:0] slot_ph;
    logic            in_stb;

    always_comb begin
        slot_ph = (phase >= L_HALF) ? phase - L_HALF : phase;
        in_stb  = (phase >= L_STB0) && (phase <= L_STB1);
        pins    = PINS_IDLE;
        unique case (kind)
            K_FETCH: begin
                pins.ale    = slot_ph < L_ALE;
                pins.psen_n = slot_ph < L_ADR;
                pins.ad_oe  = slot_ph < L_ADR;
                pins.ad     = addr[DATA_W-1:0];
                pins.hi     = addr[ADDR_W-1:DATA_W];
            end
            K_READ: begin
                pins.ale   = phase < L_ALE;
                pins.ad_oe = phase < L_ADR;
                pins.ad    = addr[DATA_W-1:0];
                pins.hi    = addr[ADDR_W-1:DATA_W];
                pins.rd_n  = !in_stb;
            end
            K_WRITE: begin
                pins.ale   = phase < L_ALE;
                pins.ad_oe = 1'b1;
                pins.ad    = (phase < L_ADR) ? addr[DATA_W-1:0] : wdata;
                pins.hi    = addr[ADDR_W-1:DATA_W];
                pins.wr_n  = !in_stb;
            end
            default: pins = PINS_IDLE;
        endcase
    end
endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
    import xbus_pkg::*;
#(
    parameter int CYC_LEN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_req,
    input  logic              xfer_we,
    input  logic              xfer_wide,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic [DATA_W-1:0] xfer_wdata,
    input  logic [HI_W-1:0]   hi_port_val,
    input  logic              jump_valid,
    input  logic [ADDR_W-1:0] jump_addr,
    output logic              xfer_done,
    output logic [DATA_W-1:0] xfer_rdata,
    output logic              instr_valid,
    output logic [DATA_W-1:0] instr_byte,
    output logic              bus_ale,
    output logic              bus_psen_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [HI_W-1:0]   hi_addr
);
    localparam int PH_W = $clog2(CYC_LEN);
    localparam int HALF = CYC_LEN / 2;
    localparam logic [PH_W-1:0] P_SLOT_END = PH_W'(HALF - 1);
    localparam logic [PH_W-1:0] P_SLOT2    = PH_W'(HALF);
    localparam logic [PH_W-1:0] P_SAMPLE   = PH_W'(CYC_LEN - 2);

    typedef struct packed {
        cyc_kind_e         kind;
        logic [ADDR_W-1:0] xaddr;
        logic [DATA_W-1:0] xwd;
        pins_t             pins;
        logic [DATA_W-1:0] instr;
        logic              instr_v;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } st_t;

    localparam st_t ST_RST = '{kind: K_IDLE, xaddr: '0, xwd: '0, pins: PINS_IDLE,
                               instr: '0, instr_v: 1'b0, rdata: '0, done: 1'b0};

    st_t st_d, st_q;

    logic [PH_W-1:0]   phase_q, phase_d;
    logic              at_last;
    cyc_kind_e         kind_nx;
    logic [ADDR_W-1:0] xaddr_nx;
    logic [DATA_W-1:0] xwd_nx;
    logic              capture, slot_start;
    logic [ADDR_W-1:0] cur_d, cur_q;
    logic [ADDR_W-1:0] dec_addr;
    pins_t             pins_nx;

    xbus_phase_ctr #(.CYC_LEN(CYC_LEN)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_q (phase_q),
        .phase_d (phase_d),
        .at_last (at_last)
    );

    // Cycle kind and transfer operands are sampled only at the machine-cycle boundary.
    always_comb begin
        kind_nx  = st_q.kind;
        xaddr_nx = st_q.xaddr;
        xwd_nx   = st_q.xwd;
        if (at_last) begin
            kind_nx = xfer_req ? (xfer_we ? K_WRITE : K_READ) : K_FETCH;
            if (xfer_req) begin
                xaddr_nx = {xfer_wide ? xfer_addr[ADDR_W-1:DATA_W] : hi_port_val,
                            xfer_addr[DATA_W-1:0]};
                xwd_nx   = xfer_wdata;
            end
        end
        capture    = (st_q.kind == K_FETCH) && ((phase_q == P_SLOT_END) || at_last);
        slot_start = (kind_nx == K_FETCH) && ((phase_d == '0) || (phase_d == P_SLOT2));
    end

    xbus_fetch_ptr #(.AW(ADDR_W)) u_fptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .slot_start (slot_start),
        .jump_valid (jump_valid),
        .jump_addr  (jump_addr),
        .cur_d      (cur_d),
        .cur_q      (cur_q)
    );

    assign dec_addr = (kind_nx == K_FETCH) ? cur_d : xaddr_nx;

    xbus_strobe_dec #(.CYC_LEN(CYC_LEN)) u_dec (
        .phase (phase_d),
        .kind  (kind_nx),
        .addr  (dec_addr),
        .wdata (xwd_nx),
        .pins  (pins_nx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.kind    = kind_nx;
        st_d.xaddr   = xaddr_nx;
        st_d.xwd     = xwd_nx;
        st_d.pins    = pins_nx;
        st_d.instr_v = 1'b0;
        st_d.done    = 1'b0;
        if (capture) begin
            st_d.instr   = ad_in;
            st_d.instr_v = 1'b1;
        end
        if ((st_q.kind == K_READ) && (phase_q == P_SAMPLE))
            st_d.rdata = ad_in;
        if (((st_q.kind == K_READ) || (st_q.kind == K_WRITE)) && (phase_q == P_SAMPLE))
            st_d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign xfer_done   = st_q.done;
    assign xfer_rdata  = st_q.rdata;
    assign instr_valid = st_q.instr_v;
    assign instr_byte  = st_q.instr;
    assign bus_ale     = st_q.pins.ale;
    assign bus_psen_n  = st_q.pins.psen_n;
    assign bus_rd_n    = st_q.pins.rd_n;
    assign bus_wr_n    = st_q.pins.wr_n;
    assign ad_out      = st_q.pins.ad;
    assign ad_oe       = st_q.pins.ad_oe;
    assign hi_addr     = st_q.pins.hi;

    logic unused_ok;
    assign unused_ok = ^cur_q;
endmodule

// File: rtl/xbus_sequencer_chk.sv
module xbus_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_ale,
    input logic bus_psen_n,
    input logic bus_rd_n,
    input logic bus_wr_n,
    input logic ad_oe,
    input logic xfer_done,
    input logic instr_valid
);
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n) && !(!bus_psen_n && !(bus_rd_n && bus_wr_n)));

    p_psen_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_psen_n |-> !ad_oe);

    p_ale_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> ad_oe);

    p_ale_min_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ale) |=> bus_ale);

    p_ale_max_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale && $past(bus_ale)) |=> !bus_ale);

    p_rd_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !ad_oe);

    p_wr_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> ad_oe);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    p_no_fetch_in_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!instr_valid && bus_psen_n));

    p_instr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> !instr_valid);
endmodule

bind xbus_sequencer xbus_sequencer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_ale     (bus_ale),
    .bus_psen_n  (bus_psen_n),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n),
    .ad_oe       (ad_oe),
    .xfer_done   (xfer_done),
    .instr_valid (instr_valid)
);

// File: tb/tb_xbus_sequencer.sv
`timescale 1ns/1ps
module tb_xbus_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_req = 1'b0, xfer_we = 1'b0, xfer_wide = 1'b0;
    logic [15:0] xfer_addr = '0;
    logic [7:0]  xfer_wdata = '0, hi_port_val = '0;
    logic        jump_valid = 1'b0;
    logic [15:0] jump_addr = '0;
    logic        xfer_done, instr_valid, bus_ale, bus_psen_n, bus_rd_n, bus_wr_n, ad_oe;
    logic [7:0]  xfer_rdata, instr_byte, ad_out, ad_in, hi_addr;

    int nchk = 0, nerr = 0, ph = 11;
    logic [15:0] exp_pc = '0;
    logic [15:0] lat = '0;

    always #2.5 clk = ~clk;

    xbus_sequencer dut (
        .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_we(xfer_we),
        .xfer_wide(xfer_wide), .xfer_addr(xfer_addr), .xfer_wdata(xfer_wdata),
        .hi_port_val(hi_port_val), .jump_valid(jump_valid), .jump_addr(jump_addr),
        .xfer_done(xfer_done), .xfer_rdata(xfer_rdata), .instr_valid(instr_valid),
        .instr_byte(instr_byte), .bus_ale(bus_ale), .bus_psen_n(bus_psen_n),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .hi_addr(hi_addr)
    );

    function automatic logic [7:0] code_of(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] data_of(input logic [15:0] a);
        return a[7:0] + a[15:8] + 8'h21;
    endfunction

    // External memory model: latch address while the latch strobe is high.
    always @(negedge clk) if (bus_ale) lat <= {hi_addr, ad_out};
    assign ad_in = !bus_psen_n ? code_of(lat) : (!bus_rd_n ? data_of(lat) : 8'h00);

    // Bench phase count, derived from the reset release.
    always @(posedge clk) ph <= !rst_n ? 11 : (ph == 11 ? 0 : ph + 1);

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h t=%0t", rq, what, act, exp, $time);
        end
    endtask

    // One six-period fetch slot, entered at slot period 0; leaves at the next slot period 0.
    task automatic fetch_half(input logic [15:0] a, input int jump_s, input logic [15:0] ja);
        for (int s = 0; s < 6; s++) begin
            chk("R2", bus_ale, s < 2, "latch strobe");
            chk("R3", bus_psen_n, !(s >= 3), "program strobe");
            chk("R3", ad_oe, s < 3, "low port enable");
            if (s < 3) chk("R4", ad_out, a[7:0], "low address");
            chk("R5", hi_addr, a[15:8], "high address");
            chk("R10", {bus_rd_n, bus_wr_n}, 2'b11, "data strobes idle");
            if (s == jump_s) begin jump_valid = 1'b1; jump_addr = ja; end
            else jump_valid = 1'b0;
            @(negedge clk);
        end
        jump_valid = 1'b0;
        chk("R4", instr_valid, 1, "instr valid");
        chk("R4", instr_byte, code_of(a), "instr byte");
        exp_pc = (jump_s >= 0) ? ja : a + 16'd1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", bus_ale, 0, "reset latch strobe");
        chk("R1", {bus_psen_n, bus_rd_n, bus_wr_n}, 3'b111, "reset strobes");
        chk("R1", ad_oe, 0, "reset low port");
        chk("R1", {instr_valid, xfer_done}, 2'b00, "reset pulses");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", ph, 0, "phase after release");
        chk("R1", {hi_addr, ad_out}, 16'h0000, "first fetch address");
        chk("R1", bus_ale, 1, "first latch pulse");
        exp_pc = 16'h0000;
    endtask

    task automatic t_seq_fetch(input int n);
        for (int i = 0; i < n; i++) fetch_half(exp_pc, -1, 16'h0);
    endtask

    task automatic t_jump(input int s, input logic [15:0] ja);
        fetch_half(exp_pc, s, ja);
        chk("R11", {hi_addr, ad_out}, ja, "jump target on bus");
    endtask

    task automatic t_xfer(input logic we, input logic wide, input logic [15:0] a,
                          input logic [7:0] wd, input logic [7:0] hr);
        logic [7:0] hi_exp;
        while (ph != 6) fetch_half(exp_pc, -1, 16'h0);
        xfer_req = 1'b1; xfer_we = we; xfer_wide = wide;
        xfer_addr = a; xfer_wdata = wd; hi_port_val = hr;
        fetch_half(exp_pc, -1, 16'h0);
        hi_exp = wide ? a[15:8] : hr;
        for (int p = 0; p < 12; p++) begin
            chk("R6", bus_ale, p < 2, "transfer latch strobe");
            chk("R6", bus_psen_n, 1, "program strobe held off");
            if (p > 0) chk("R6", instr_valid, 0, "no fetch in transfer");
            chk("R9", hi_addr, hi_exp, "transfer high port");
            chk("R7", bus_rd_n, !(!we && p >= 4 && p <= 10), "read strobe");
            chk("R8", bus_wr_n, !(we && p >= 4 && p <= 10), "write strobe");
            chk(we ? "R8" : "R7", ad_oe, we ? 1 : (p < 3), "low port enable");
            if (p < 3) chk("R9", ad_out, a[7:0], "transfer low address");
            else if (we) chk("R8", ad_out, wd, "write data");
            chk("R7", xfer_done, p == 11, "done pulse");
            if (p == 11 && !we) chk("R7", xfer_rdata, data_of({hi_exp, a[7:0]}), "read data");
            if (p == 1) begin hi_port_val = ~hr; xfer_addr = ~a; xfer_wdata = ~wd; end
            if (p == 11) xfer_req = 1'b0;
            @(negedge clk);
        end
        chk("R6", {hi_addr, ad_out}, exp_pc, "fetch resumes");
        fetch_half(exp_pc, -1, 16'h0);
    endtask

    initial begin
        #500000;
        nerr++; nchk++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        t_reset();
        t_seq_fetch(4);
        t_jump(1, 16'h8000);
        t_jump(5, 16'h0FFE);
        t_seq_fetch(3);
        t_xfer(1'b0, 1'b0, 16'h1234, 8'h00, 8'hA5);
        t_xfer(1'b1, 1'b1, 16'hBEEF, 8'h3C, 8'h11);
        t_xfer(1'b0, 1'b1, 16'h7E81, 8'h00, 8'h22);
        t_xfer(1'b1, 1'b0, 16'h4455, 8'hC3, 8'h9D);
        t_seq_fetch(2);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule